// File: doc/BRIEF.md
# Phase-Continuous Numerically Controlled Oscillator Core

This block is the phase engine of a direct digital synthesizer. A wide phase register advances by a programmable frequency step on every system clock and wraps around silently. The step value is loaded a byte at a time through a small write port into a holding copy. It only takes effect when a separate commit strobe arrives, so a multi-byte retune never produces an intermediate frequency. Committing a new step changes the rate of phase advance from the next clock on. The phase itself is never cleared or stepped, so the synthesized waveform stays continuous.

The output frequency is the step value divided by two to the power of the phase width, multiplied by the clock rate. A registered, truncated copy of the phase feeds a downstream phase-to-amplitude stage. The untruncated phase is offered as well, for spur-cancelling harmonic generators. A 4-bit strap input chooses the step value that applies after a hard reset.

Top module: `nco_phase_core`

## Requirements
- R1: While `hard_rst` is high at a clock edge, that edge sets `full_phase` and `lut_phase` to zero.
- R2: A hard reset loads both the holding and the active step value with the strap default s·2^32 + s, where s is the 4-bit unsigned value on `strap` at that edge.
- R3: At each edge without reset, `full_phase` becomes its previous value plus the active step value, modulo 2^48, with no overflow indication.
- R4: A write with `wr_en` high to address TW_BASE+k (k = 0..5, default TW_BASE = 0x1A6) replaces bits [8k+7:8k] of the holding copy. Byte 0 is least significant. The active step value is unchanged until a commit.
- R5: `upd` high at an edge copies the whole 48-bit holding value into the active step value in that edge. The phase increment at that same edge still uses the old value, the next edge uses the new one, and the phase is not reset.
- R6: A byte write and `upd` at the same edge commit the holding value including that newly written byte.
- R7: Writes to any address outside TW_BASE..TW_BASE+5 change neither the holding nor the active step value.
- R8: `lut_phase` equals bits [47:34] of the `full_phase` value present before the same edge (one cycle of latency).
- R9: `strap` is ignored while `hard_rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| hard_rst | input | 1 | Synchronous hard reset, active high; straps sampled while high |
| strap | input | 4 | Selects the post-reset step value |
| wr_en | input | 1 | Byte write enable |
| wr_addr | input | 12 | Byte write address |
| wr_data | input | 8 | Byte write data |
| upd | input | 1 | Commit strobe: holding copy to active step value |
| lut_phase | output | 14 | Registered top bits of the phase, for the amplitude stage |
| full_phase | output | 48 | Full phase register value |

## Verification
Two functions can fall on the same edge here. A byte write can coincide with the commit strobe, and a commit always coincides with a phase advance that must still use the old step. The bench writes the top byte of a new step value in the very cycle it raises `upd`. Its model expects the committed word to contain that byte. It also expects the increment at the commit edge to be the old step and the following increment the new one. A near-full-scale step placed that way also forces the wrap on the cycles right after the commit.

// File: rtl/nco_pkg.sv
package nco_pkg;

  localparam int unsigned DEF_ACC_W   = 48;
  localparam int unsigned DEF_OUT_W   = 14;
  localparam int unsigned DEF_BYTE_W  = 8;
  localparam int unsigned DEF_ADDR_W  = 12;
  localparam int unsigned DEF_STRAP_W = 4;
  localparam int unsigned DEF_TW_BASE = 32'h1A6;

  // Post-reset step value for a strap setting: s * (2^32 + 1).
  function automatic logic [63:0] strap_default(input logic [15:0] s);
    logic [63:0] wide;
    wide = {48'b0, s};
    return (wide << 32) | wide;
  endfunction

  // Byte address decode against the tuning word window.
  function automatic logic in_window(input int unsigned addr,
                                     input int unsigned base,
                                     input int unsigned nbytes);
    return (addr >= base) && (addr < base + nbytes);
  endfunction

endpackage

// File: rtl/nco_tw_regs.sv
module nco_tw_regs #(
  parameter int unsigned ACC_W   = nco_pkg::DEF_ACC_W,
  parameter int unsigned BYTE_W  = nco_pkg::DEF_BYTE_W,
  parameter int unsigned ADDR_W  = nco_pkg::DEF_ADDR_W,
  parameter int unsigned STRAP_W = nco_pkg::DEF_STRAP_W,
  parameter int unsigned TW_BASE = nco_pkg::DEF_TW_BASE
) (
  input  logic               clk,
  input  logic               hard_rst,
  input  logic [STRAP_W-1:0] strap,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [BYTE_W-1:0]  wr_data,
  input  logic               upd,
  output logic [ACC_W-1:0]   ftw_shadow,
  output logic [ACC_W-1:0]   ftw_active,
  output logic               addr_hit
);
  localparam int unsigned NBYTES = ACC_W / BYTE_W;

  logic [ACC_W-1:0]  shadow_q;
  logic [ACC_W-1:0]  shadow_d;
  logic [ACC_W-1:0]  active_q;
  logic [ACC_W-1:0]  strap_ftw;
  logic [NBYTES-1:0] byte_hit;

  assign strap_ftw = ACC_W'(nco_pkg::strap_default(16'(strap)));

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    assign byte_hit[k] = wr_en && (wr_addr == ADDR_W'(TW_BASE + k));
    assign shadow_d[k*BYTE_W +: BYTE_W] =
      byte_hit[k] ? wr_data : shadow_q[k*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (hard_rst) begin
      shadow_q <= strap_ftw;
      active_q <= strap_ftw;
    end else begin
      shadow_q <= shadow_d;
      if (upd) active_q <= shadow_d;
    end
  end

  assign ftw_shadow = shadow_q;
  assign ftw_active = active_q;
  assign addr_hit   = |byte_hit;
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int unsigned ACC_W = nco_pkg::DEF_ACC_W
) (
  input  logic             clk,
  input  logic             hard_rst,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] phase
);
  logic [ACC_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (hard_rst) phase_q <= '0;
    else          phase_q <= phase_q + step;
  end

  assign phase = phase_q;
endmodule

// File: rtl/nco_phase_tap.sv
module nco_phase_tap #(
  parameter int unsigned OUT_W = nco_pkg::DEF_OUT_W
) (
  input  logic             clk,
  input  logic             hard_rst,
  input  logic [OUT_W-1:0] phase_hi,
  output logic [OUT_W-1:0] tap
);
  logic [OUT_W-1:0] tap_q;

  always_ff @(posedge clk) begin
    if (hard_rst) tap_q <= '0;
    else          tap_q <= phase_hi;
  end

  assign tap = tap_q;
endmodule

// File: rtl/nco_phase_core.sv
module nco_phase_core #(
  parameter int unsigned ACC_W   = nco_pkg::DEF_ACC_W,
  parameter int unsigned OUT_W   = nco_pkg::DEF_OUT_W,
  parameter int unsigned BYTE_W  = nco_pkg::DEF_BYTE_W,
  parameter int unsigned ADDR_W  = nco_pkg::DEF_ADDR_W,
  parameter int unsigned STRAP_W = nco_pkg::DEF_STRAP_W,
  parameter int unsigned TW_BASE = nco_pkg::DEF_TW_BASE
) (
  input  logic               clk,
  input  logic               hard_rst,
  input  logic [STRAP_W-1:0] strap,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [BYTE_W-1:0]  wr_data,
  input  logic               upd,
  output logic [OUT_W-1:0]   lut_phase,
  output logic [ACC_W-1:0]   full_phase
);
  // Named internal events, visible to the bound checker.
  logic [ACC_W-1:0] ftw_shadow;
  logic [ACC_W-1:0] ftw_active;
  logic             tw_addr_hit;

  nco_tw_regs #(
    .ACC_W(ACC_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W),
    .STRAP_W(STRAP_W), .TW_BASE(TW_BASE)
  ) u_regs (
    .clk(clk), .hard_rst(hard_rst), .strap(strap),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .upd(upd),
    .ftw_shadow(ftw_shadow), .ftw_active(ftw_active), .addr_hit(tw_addr_hit)
  );

  nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .hard_rst(hard_rst), .step(ftw_active), .phase(full_phase)
  );

  nco_phase_tap #(.OUT_W(OUT_W)) u_tap (
    .clk(clk), .hard_rst(hard_rst),
    .phase_hi(full_phase[ACC_W-1 -: OUT_W]), .tap(lut_phase)
  );
endmodule

// File: rtl/nco_phase_chk.sv
module nco_phase_chk #(
  parameter int unsigned ACC_W = nco_pkg::DEF_ACC_W,
  parameter int unsigned OUT_W = nco_pkg::DEF_OUT_W
) (
  input logic             clk,
  input logic             hard_rst,
  input logic             upd,
  input logic             wr_en,
  input logic             tw_addr_hit,
  input logic [ACC_W-1:0] full_phase,
  input logic [ACC_W-1:0] ftw_active,
  input logic [ACC_W-1:0] ftw_shadow,
  input logic [OUT_W-1:0] lut_phase
);
  logic primed   = 1'b0;
  logic prev_rst = 1'b1;

  always_ff @(posedge clk) begin
    prev_rst <= hard_rst;
    if (hard_rst) primed <= 1'b1;
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    hard_rst |=> (full_phase == '0) && (lut_phase == '0));

  // R3
  accum_step_chk: assert property (@(posedge clk) disable iff (hard_rst)
    (primed && !prev_rst) |-> full_phase == $past(full_phase) + $past(ftw_active));

  // R4
  hold_active_chk: assert property (@(posedge clk) disable iff (hard_rst)
    (primed && !upd) |=> $stable(ftw_active));

  // R5
  commit_load_chk: assert property (@(posedge clk) disable iff (hard_rst)
    (primed && upd && !wr_en) |=> ftw_active == $past(ftw_shadow));

  // R6
  commit_merge_chk: assert property (@(posedge clk) disable iff (hard_rst)
    (primed && upd) |=> ftw_active == ftw_shadow);

  // R7
  stray_write_chk: assert property (@(posedge clk) disable iff (hard_rst)
    (primed && wr_en && !tw_addr_hit) |=> $stable(ftw_shadow));

  // R8
  lut_tap_chk: assert property (@(posedge clk) disable iff (hard_rst)
    primed |=> lut_phase == $past(full_phase[ACC_W-1 -: OUT_W]));
endmodule

bind nco_phase_core nco_phase_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .hard_rst(hard_rst), .upd(upd), .wr_en(wr_en),
  .tw_addr_hit(tw_addr_hit), .full_phase(full_phase),
  .ftw_active(ftw_active), .ftw_shadow(ftw_shadow), .lut_phase(lut_phase)
);

// File: tb/tb_nco_phase_core.sv
module tb_nco_phase_core;
  localparam int CLK_PERIOD = 10;
  localparam int unsigned BASE = 32'h1A6;

  logic        clk = 1'b0;
  logic        hard_rst = 1'b1;
  logic [3:0]  strap = 4'd0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        upd = 1'b0;
  logic [13:0] lut_phase;
  logic [47:0] full_phase;

  nco_phase_core dut (
    .clk(clk), .hard_rst(hard_rst), .strap(strap), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .upd(upd),
    .lut_phase(lut_phase), .full_phase(full_phase)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [47:0] f;
    logic [13:0] l;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Independent reference state.
  logic [47:0] m_acc = '0, m_act = '0, m_sh = '0;
  logic [13:0] m_lut = '0;

  function automatic logic [47:0] def_ftw(input logic [3:0] s);
    return ({44'b0, s} << 32) + {44'b0, s};
  endfunction

  task automatic step(input logic rst, input logic [3:0] s, input logic we,
                      input logic [11:0] a, input logic [7:0] d,
                      input logic up, input string tag);
    exp_t e;
    logic [47:0] nsh;
    @(negedge clk);
    hard_rst = rst; strap = s; wr_en = we; wr_addr = a; wr_data = d; upd = up;
    if (rst) begin
      m_acc = '0; m_lut = '0; m_sh = def_ftw(s); m_act = def_ftw(s);
    end else begin
      nsh = m_sh;
      if (we && a >= 12'(BASE) && a < 12'(BASE + 6))
        nsh[(a - 12'(BASE))*8 +: 8] = d;
      m_lut = m_acc[47:34];
      m_acc = m_acc + m_act;
      m_sh  = nsh;
      if (up) m_act = nsh;
    end
    e.f = m_acc; e.l = m_lut; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n, input logic [3:0] s, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, s, 1'b0, '0, '0, 1'b0, tag);
  endtask

  task automatic load_ftw(input logic [47:0] v, input logic commit_last,
                          input logic [3:0] s, input string tag);
    for (int k = 0; k < 6; k++)
      step(1'b0, s, 1'b1, 12'(BASE + k), v[k*8 +: 8],
           commit_last && (k == 5), tag);
  endtask

  // Monitor: compare each edge's result against the queued expectation.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (full_phase !== e.f || lut_phase !== e.l) begin
          errors++;
          $display("FAIL %s: full_phase=%h exp=%h lut_phase=%h exp=%h",
                   e.tag, full_phase, e.f, lut_phase, e.l);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 / R2: reset with strap 5, then run on the strap default.
    for (int i = 0; i < 3; i++) step(1'b1, 4'd5, 1'b0, '0, '0, 1'b0, "R1");
    idle(4, 4'd5, "R2");
    // R9: strap moves after reset, no effect.
    idle(3, 4'hA, "R9");
    // R4: bytes land in the holding copy only.
    load_ftw(48'h0123_4567_89AB, 1'b0, 4'hA, "R4");
    idle(2, 4'hA, "R4");
    // R5: commit alone, phase continues.
    step(1'b0, 4'hA, 1'b0, '0, '0, 1'b1, "R5");
    idle(3, 4'hA, "R5");
    // R6: last byte written in the commit cycle; R3: wrap follows.
    load_ftw(48'hFFFF_FFFF_FFF1, 1'b1, 4'hA, "R6");
    idle(5, 4'hA, "R3");
    // R7: writes just outside the window, then commit.
    step(1'b0, 4'hA, 1'b1, 12'(BASE - 1), 8'h00, 1'b0, "R7");
    step(1'b0, 4'hA, 1'b1, 12'(BASE + 6), 8'h00, 1'b1, "R7");
    idle(3, 4'hA, "R7");
    // R8: large step so the truncated tap moves every cycle.
    load_ftw(48'h1357_0000_0000, 1'b1, 4'hA, "R8");
    idle(6, 4'hA, "R8");
    // R1 / R2: second reset with strap 0 gives a frozen phase.
    for (int i = 0; i < 2; i++) step(1'b1, 4'd0, 1'b0, '0, '0, 1'b0, "R1");
    idle(3, 4'd0, "R2");
    while (exp_q.size() > 0) @(posedge clk);
    #(CLK_PERIOD);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule